// File: doc/BRIEF.md
# Victim Line Buffer

The victim line buffer is a small, fully associative store that sits beside a direct-mapped L1 data cache. Its only source of lines is the L1 itself. Each line that L1 throws out is offered on the eviction port together with its address and a dirty flag. Lines fetched from the lower level are never placed in the buffer.

When L1 misses, it presents the wanted line address on the lookup port. The address is compared against every valid entry in one cycle. On a hit, the buffer returns the line and its dirty flag, and no lower-level access is made. In the same transaction, the L1 line that the refill displaces is written into the entry just freed, so the two lines swap places. On a miss, the buffer issues a request to the lower level. It then relays the returned line to L1 as a miss response.

When every entry is valid, a new eviction replaces the entry that was filled longest ago, as chosen by a rotating pointer. If that entry is dirty, it is first offered on the writeback port. The buffer holds it there until the lower level acknowledges it.

Top module: `victim_buf`

## Requirements
- R1: After reset, every entry is invalid, the replacement pointer is at entry 0, `rsp_valid`, `mem_req_valid` and `wb_valid` are low, and `lk_ready` and `ev_ready` are high; a lookup after reset therefore misses.
- R2: An accepted eviction is stored in the lowest-numbered invalid entry when one exists. A later lookup hits only when every bit of its address equals the stored line address.
- R3: A lookup that hits raises `rsp_valid` for one cycle, on the first clock edge after acceptance, with `rsp_hit`=1 and the stored data and dirty flag. `mem_req_valid` stays low for that lookup.
- R4: On a hit with `dsp_valid`=1, the displaced line (address, data, dirty) takes the entry that hit, and the requested line leaves the buffer. On a hit with `dsp_valid`=0, that entry becomes invalid.
- R5: A lookup that misses raises `mem_req_valid` with `mem_req_addr` equal to the lookup address on the first edge after acceptance. The request is held until `mem_req_ready`. One edge after `mem_rsp_valid`, a one-cycle `rsp_valid` appears with `rsp_hit`=0, `rsp_dirty`=0 and the returned data.
- R6: While a miss or a writeback is in progress, `lk_ready` and `ev_ready` are low. In a cycle where `lk_valid` is high, `ev_ready` is low, so a lookup takes priority over an eviction.
- R7: When all entries are valid, an eviction replaces the entry at the pointer, and the pointer then advances by one, wrapping after entry DEPTH-1. A clean entry is overwritten at once, with no writeback.
- R8: If the entry to be replaced is dirty, `wb_valid` rises on the first edge after the eviction is accepted, carrying that entry's address and data. These values stay stable until `wb_ready`. The new line is written on the edge where `wb_ready` is seen.
- R9: A line returned by the lower level is not allocated, so a repeated lookup of that address misses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_valid | input | 1 | L1 offers an evicted line |
| ev_ready | output | 1 | Eviction accepted this cycle when high together with ev_valid |
| ev_addr | input | ADDR_W | Line address of the evicted line |
| ev_data | input | LINE_W | Data of the evicted line |
| ev_dirty | input | 1 | Evicted line is modified |
| lk_valid | input | 1 | L1 miss lookup request |
| lk_ready | output | 1 | Lookup accepted this cycle when high together with lk_valid |
| lk_addr | input | ADDR_W | Line address being looked up |
| dsp_valid | input | 1 | L1 has a line that the refill displaces |
| dsp_addr | input | ADDR_W | Address of the displaced L1 line |
| dsp_data | input | LINE_W | Data of the displaced L1 line |
| dsp_dirty | input | 1 | Displaced L1 line is modified |
| rsp_valid | output | 1 | One-cycle lookup response |
| rsp_hit | output | 1 | Response came from the buffer |
| rsp_data | output | LINE_W | Line data of the response |
| rsp_dirty | output | 1 | Returned line is modified |
| mem_req_valid | output | 1 | Read request to the lower level |
| mem_req_ready | input | 1 | Lower level takes the request |
| mem_req_addr | output | ADDR_W | Requested line address |
| mem_rsp_valid | input | 1 | Lower level returns the line |
| mem_rsp_data | input | LINE_W | Returned line data |
| wb_valid | output | 1 | Dirty line being written back |
| wb_ready | input | 1 | Lower level takes the writeback |
| wb_addr | output | ADDR_W | Writeback line address |
| wb_data | output | LINE_W | Writeback line data |

## Verification
A hit response is due one edge after the lookup is accepted. A miss request is due on that same edge. The relayed miss response follows one edge after `mem_rsp_valid`. A writeback appears one edge after the eviction that forces it. The bench drives every input on the falling edge and samples every output on the next falling edge, exactly one rising edge later. It holds `mem_req_ready` and `wb_ready` low for an extra cycle to check that the request and writeback stay put. Effects on the buffer's contents, such as swaps, replacements and reset clearing, are observed through later lookups.

// File: rtl/vb_pkg.sv
package vb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MREQ  = 2'd1,
    ST_MWAIT = 2'd2,
    ST_WB    = 2'd3
  } vb_state_t;
endpackage

// File: rtl/vb_match.sv
module vb_match #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic [DEPTH-1:0]             vld,
  input  logic [DEPTH-1:0][ADDR_W-1:0] tags,
  input  logic [ADDR_W-1:0]            key,
  output logic [DEPTH-1:0]             hit_vec,
  output logic                         hit,
  output logic [IDX_W-1:0]             hit_idx,
  output logic                         free_any,
  output logic [IDX_W-1:0]             free_idx
);
  // one full-width comparator per entry
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_vec[g] = vld[g] && (tags[g] == key);
  end

  assign hit      = |hit_vec;
  assign free_any = ~&vld;

  // lowest index wins for both encoders
  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx  = IDX_W'(i);
      if (!vld[i])    free_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/vb_ptr.sv
module vb_ptr #(
  parameter int DEPTH = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  logic [IDX_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (adv) begin
      ptr_d = (ptr_q == IDX_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr_q) < DEPTH); // R7
endmodule

// File: rtl/victim_buf.sv
module victim_buf #(
  parameter int ADDR_W = 16,
  parameter int LINE_W = 64,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [LINE_W-1:0] ev_data,
  input  logic              ev_dirty,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              dsp_valid,
  input  logic [ADDR_W-1:0] dsp_addr,
  input  logic [LINE_W-1:0] dsp_data,
  input  logic              dsp_dirty,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [LINE_W-1:0] rsp_data,
  output logic              rsp_dirty,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [LINE_W-1:0] mem_rsp_data,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [LINE_W-1:0] wb_data
);
  import vb_pkg::*;

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // reset: asserted asynchronously, released through two flops
  logic rst_s1_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_sync_n <= rst_s1_q;
    end
  end

  // entry storage
  logic [DEPTH-1:0]             valid_q, valid_d;
  logic [DEPTH-1:0][ADDR_W-1:0] tag_q, tag_d;
  logic [DEPTH-1:0][LINE_W-1:0] data_q, data_d;
  logic [DEPTH-1:0]             dirty_q, dirty_d;
  logic                         tbl_we;

  // control state
  vb_state_t         st_q, st_d;
  logic [ADDR_W-1:0] miss_addr_q, miss_addr_d;
  logic [ADDR_W-1:0] pend_addr_q, pend_addr_d;
  logic [LINE_W-1:0] pend_data_q, pend_data_d;
  logic              pend_dirty_q, pend_dirty_d;
  logic              pend_we;

  // response registers
  logic              rsp_v_q, rsp_v_d;
  logic              rsp_hit_q, rsp_hit_d;
  logic [LINE_W-1:0] rsp_data_q, rsp_data_d;
  logic              rsp_dirty_q, rsp_dirty_d;

  // matcher and pointer
  logic [DEPTH-1:0] m_vec;
  logic             m_hit, free_any;
  logic [IDX_W-1:0] m_idx, free_idx, ptr;
  logic             ptr_adv;

  vb_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_match (
    .vld      (valid_q),
    .tags     (tag_q),
    .key      (lk_addr),
    .hit_vec  (m_vec),
    .hit      (m_hit),
    .hit_idx  (m_idx),
    .free_any (free_any),
    .free_idx (free_idx)
  );

  vb_ptr #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ptr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .adv   (ptr_adv),
    .ptr   (ptr)
  );

  // handshakes
  logic lk_fire, ev_fire;
  assign lk_ready = (st_q == ST_IDLE);
  assign ev_ready = (st_q == ST_IDLE) && !lk_valid;
  assign lk_fire  = lk_valid && lk_ready;
  assign ev_fire  = ev_valid && ev_ready;

  assign mem_req_valid = (st_q == ST_MREQ);
  assign mem_req_addr  = miss_addr_q;
  assign wb_valid      = (st_q == ST_WB);
  assign wb_addr       = tag_q[ptr];
  assign wb_data       = data_q[ptr];

  assign rsp_valid = rsp_v_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_data  = rsp_data_q;
  assign rsp_dirty = rsp_dirty_q;

  // next-state logic
  always_comb begin
    st_d         = st_q;
    valid_d      = valid_q;
    tag_d        = tag_q;
    data_d       = data_q;
    dirty_d      = dirty_q;
    tbl_we       = 1'b0;
    miss_addr_d  = miss_addr_q;
    pend_addr_d  = pend_addr_q;
    pend_data_d  = pend_data_q;
    pend_dirty_d = pend_dirty_q;
    pend_we      = 1'b0;
    ptr_adv      = 1'b0;
    rsp_v_d      = 1'b0;
    rsp_hit_d    = rsp_hit_q;
    rsp_data_d   = rsp_data_q;
    rsp_dirty_d  = rsp_dirty_q;

    unique case (st_q)
      ST_IDLE: begin
        if (lk_fire) begin
          if (m_hit) begin
            rsp_v_d        = 1'b1;
            rsp_hit_d      = 1'b1;
            rsp_data_d     = data_q[m_idx];
            rsp_dirty_d    = dirty_q[m_idx];
            tbl_we         = 1'b1;
            valid_d[m_idx] = dsp_valid;
            if (dsp_valid) begin
              tag_d[m_idx]   = dsp_addr;
              data_d[m_idx]  = dsp_data;
              dirty_d[m_idx] = dsp_dirty;
            end
          end else begin
            miss_addr_d = lk_addr;
            st_d        = ST_MREQ;
          end
        end else if (ev_fire) begin
          if (free_any) begin
            tbl_we            = 1'b1;
            valid_d[free_idx] = 1'b1;
            tag_d[free_idx]   = ev_addr;
            data_d[free_idx]  = ev_data;
            dirty_d[free_idx] = ev_dirty;
          end else if (!dirty_q[ptr]) begin
            tbl_we       = 1'b1;
            tag_d[ptr]   = ev_addr;
            data_d[ptr]  = ev_data;
            dirty_d[ptr] = ev_dirty;
            ptr_adv      = 1'b1;
          end else begin
            pend_we      = 1'b1;
            pend_addr_d  = ev_addr;
            pend_data_d  = ev_data;
            pend_dirty_d = ev_dirty;
            st_d         = ST_WB;
          end
        end
      end
      ST_MREQ: begin
        if (mem_req_ready) st_d = ST_MWAIT;
      end
      ST_MWAIT: begin
        if (mem_rsp_valid) begin
          rsp_v_d     = 1'b1;
          rsp_hit_d   = 1'b0;
          rsp_data_d  = mem_rsp_data;
          rsp_dirty_d = 1'b0;
          st_d        = ST_IDLE;
        end
      end
      ST_WB: begin
        if (wb_ready) begin
          tbl_we       = 1'b1;
          tag_d[ptr]   = pend_addr_q;
          data_d[ptr]  = pend_data_q;
          dirty_d[ptr] = pend_dirty_q;
          ptr_adv      = 1'b1;
          st_d         = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers with reset
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q    <= ST_IDLE;
      valid_q <= '0;
      rsp_v_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      rsp_v_q <= rsp_v_d;
      if (tbl_we) valid_q <= valid_d;
    end
  end

  // datapath registers without reset
  always_ff @(posedge clk) begin
    if (tbl_we) begin
      tag_q   <= tag_d;
      data_q  <= data_d;
      dirty_q <= dirty_d;
    end
    if (pend_we) begin
      pend_addr_q  <= pend_addr_d;
      pend_data_q  <= pend_data_d;
      pend_dirty_q <= pend_dirty_d;
    end
    if (lk_fire) miss_addr_q <= miss_addr_d;
    if (rsp_v_d) begin
      rsp_hit_q   <= rsp_hit_d;
      rsp_data_q  <= rsp_data_d;
      rsp_dirty_q <= rsp_dirty_d;
    end
  end

  // checks next to the logic they guard
  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lk_valid |-> $onehot0(m_vec)); // R2
  AST_HIT_NO_MEMREQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid && rsp_hit) |-> !mem_req_valid); // R3
  AST_LK_ANSWER: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lk_valid && lk_ready) |=> (rsp_valid || mem_req_valid)); // R5
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R5
  AST_BUSY_BLOCK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_req_valid || wb_valid) |-> (!lk_ready && !ev_ready)); // R6
  AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr) && $stable(wb_data))); // R8
endmodule

// File: tb/tb_victim_buf.sv
module tb_victim_buf;
  localparam int AW = 16;
  localparam int LW = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ev_valid, ev_ready, ev_dirty;
  logic [AW-1:0] ev_addr;
  logic [LW-1:0] ev_data;
  logic          lk_valid, lk_ready;
  logic [AW-1:0] lk_addr;
  logic          dsp_valid, dsp_dirty;
  logic [AW-1:0] dsp_addr;
  logic [LW-1:0] dsp_data;
  logic          rsp_valid, rsp_hit, rsp_dirty;
  logic [LW-1:0] rsp_data;
  logic          mem_req_valid, mem_req_ready;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rsp_valid;
  logic [LW-1:0] mem_rsp_data;
  logic          wb_valid, wb_ready;
  logic [AW-1:0] wb_addr;
  logic [LW-1:0] wb_data;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  victim_buf #(.ADDR_W(AW), .LINE_W(LW), .DEPTH(4)) dut (
    .clk(clk), .rst_n(rst_n),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_addr(ev_addr),
    .ev_data(ev_data), .ev_dirty(ev_dirty),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_addr(lk_addr),
    .dsp_valid(dsp_valid), .dsp_addr(dsp_addr), .dsp_data(dsp_data),
    .dsp_dirty(dsp_dirty),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .rsp_dirty(rsp_dirty),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr),
    .wb_data(wb_data)
  );

  function automatic logic [LW-1:0] mem_pat(input logic [AW-1:0] a);
    return {4{a ^ 16'h5A5A}};
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [LW-1:0] act, input logic [LW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_evict(input logic [AW-1:0] a, input logic [LW-1:0] d,
                          input logic dt);
    ev_valid = 1'b1; ev_addr = a; ev_data = d; ev_dirty = dt;
    @(posedge clk);
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  // lookup; on a miss, plays the lower level with one stall cycle
  task automatic do_lookup(input logic [AW-1:0] a, input logic dv,
                           input logic [AW-1:0] da, input logic [LW-1:0] dd,
                           input logic ddt, input bit with_ev,
                           output logic hit, output logic [LW-1:0] data,
                           output logic dirty);
    lk_valid = 1'b1; lk_addr = a;
    dsp_valid = dv; dsp_addr = da; dsp_data = dd; dsp_dirty = ddt;
    if (with_ev) begin
      ev_valid = 1'b1; ev_addr = 16'h3333; ev_data = '1; ev_dirty = 1'b0;
      #1;
      check(ev_ready == 1'b0, "R6 lookup priority over eviction", LW'(ev_ready), 0);
    end
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0; dsp_valid = 1'b0; ev_valid = 1'b0;
    if (rsp_valid) begin
      hit = rsp_hit; data = rsp_data; dirty = rsp_dirty;
      check(!mem_req_valid, "R3 no lower request on hit", LW'(mem_req_valid), 0);
    end else begin
      check(mem_req_valid && mem_req_addr == a, "R5 request address",
            LW'(mem_req_addr), LW'(a));
      check(!lk_ready && !ev_ready, "R6 busy during miss",
            LW'({lk_ready, ev_ready}), 0);
      @(posedge clk);
      @(negedge clk);
      check(mem_req_valid && mem_req_addr == a, "R5 request held",
            LW'(mem_req_valid), 1);
      mem_req_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = mem_pat(a);
      @(posedge clk);
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      check(rsp_valid == 1'b1, "R5 miss response valid", LW'(rsp_valid), 1);
      hit = rsp_hit; data = rsp_data; dirty = rsp_dirty;
    end
  endtask

  typedef struct packed {
    logic          is_lk;
    logic [AW-1:0] addr;
    logic [LW-1:0] data;
    logic          dirty;
    logic          ehit;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'h0010, 64'h0, 1'b0, 1'b0},                   // R1 empty after reset
    '{1'b0, 16'h0010, 64'h1111_2222_3333_4444, 1'b0, 1'b0}, // R2 fill
    '{1'b0, 16'h0020, 64'hAAAA_BBBB_CCCC_DDDD, 1'b1, 1'b0}, // R2 fill
    '{1'b1, 16'h0010, 64'h1111_2222_3333_4444, 1'b0, 1'b1}, // R3 hit, frees entry
    '{1'b1, 16'h0011, 64'h0, 1'b0, 1'b0},                   // R2 low bit differs
    '{1'b1, 16'h0010, 64'h0, 1'b0, 1'b0},                   // R4 freed by hit
    '{1'b1, 16'h8020, 64'h0, 1'b0, 1'b0},                   // R2 top bit differs
    '{1'b1, 16'h0020, 64'hAAAA_BBBB_CCCC_DDDD, 1'b1, 1'b1}  // R3 dirty hit
  };

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic          h, dt;
    logic [LW-1:0] d;
    rst_n = 1'b0;
    ev_valid = 1'b0; ev_addr = '0; ev_data = '0; ev_dirty = 1'b0;
    lk_valid = 1'b0; lk_addr = '0;
    dsp_valid = 1'b0; dsp_addr = '0; dsp_data = '0; dsp_dirty = 1'b0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    wb_ready = 1'b0;
    do_reset();

    check(!rsp_valid && !mem_req_valid && !wb_valid && lk_ready && ev_ready,
          "R1 reset outputs",
          LW'({rsp_valid, mem_req_valid, wb_valid, lk_ready, ev_ready}), 64'h3);

    // vector table
    for (int i = 0; i < NV; i++) begin
      if (!VECS[i].is_lk) begin
        do_evict(VECS[i].addr, VECS[i].data, VECS[i].dirty);
      end else begin
        do_lookup(VECS[i].addr, 1'b0, '0, '0, 1'b0, 1'b0, h, d, dt);
        check(h == VECS[i].ehit, "R2 R3 R5 hit flag", LW'(h), LW'(VECS[i].ehit));
        if (VECS[i].ehit) begin
          check(d == VECS[i].data && dt == VECS[i].dirty, "R3 hit data",
                d, VECS[i].data);
        end else begin
          check(d == mem_pat(VECS[i].addr) && dt == 1'b0, "R5 miss data",
                d, mem_pat(VECS[i].addr));
        end
      end
    end

    // R4: swap with displaced line
    do_evict(16'h0100, 64'h0101_0101_0101_0101, 1'b0);
    do_lookup(16'h0100, 1'b1, 16'h0200, 64'h0202_0202_0202_0202, 1'b1, 1'b0, h, d, dt);
    check(h && d == 64'h0101_0101_0101_0101, "R4 swap hit data", d, 64'h0101_0101_0101_0101);
    do_lookup(16'h0200, 1'b0, '0, '0, 1'b0, 1'b0, h, d, dt);
    check(h && d == 64'h0202_0202_0202_0202 && dt, "R4 displaced line stored",
          d, 64'h0202_0202_0202_0202);
    do_lookup(16'h0100, 1'b0, '0, '0, 1'b0, 1'b1, h, d, dt);
    check(!h, "R4 requested line left buffer", LW'(h), 0);
    // R9: the line just returned by the lower level was not kept
    do_lookup(16'h0100, 1'b0, '0, '0, 1'b0, 1'b0, h, d, dt);
    check(!h, "R9 lower-level fill not allocated", LW'(h), 0);
    // R6: the eviction offered with that lookup was not taken
    do_lookup(16'h3333, 1'b0, '0, '0, 1'b0, 1'b0, h, d, dt);
    check(!h, "R6 eviction blocked by lookup", LW'(h), 0);

    // R7, R8: fill all four, oldest dirty
    for (int k = 0; k < 4; k++) begin
      do_evict(16'h1000 + AW'(k), {48'h0, 16'h1000 + 16'(k)}, (k == 0));
    end
    do_evict(16'h1004, 64'h4444, 1'b0);
    check(wb_valid && wb_addr == 16'h1000 && wb_data == 64'h1000, "R8 writeback offered",
          LW'(wb_addr), 64'h1000);
    check(!lk_ready && !ev_ready, "R6 busy during writeback",
          LW'({lk_ready, ev_ready}), 0);
    @(posedge clk);
    @(negedge clk);
    check(wb_valid && wb_addr == 16'h1000 && wb_data == 64'h1000, "R8 writeback held",
          LW'(wb_addr), 64'h1000);
    wb_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wb_ready = 1'b0;
    check(!wb_valid && lk_ready, "R8 writeback done", LW'(wb_valid), 0);
    do_evict(16'h1005, 64'h5555, 1'b0);
    check(!wb_valid, "R7 clean replacement has no writeback", LW'(wb_valid), 0);
    do_lookup(16'h1001, 1'b0, '0, '0, 1'b0, 1'b0, h, d, dt);
    check(!h, "R7 oldest clean line replaced", LW'(h), 0);
    do_lookup(16'h1000, 1'b0, '0, '0, 1'b0, 1'b0, h, d, dt);
    check(!h, "R8 written-back line replaced", LW'(h), 0);
    do_lookup(16'h1004, 1'b0, '0, '0, 1'b0, 1'b0, h, d, dt);
    check(h && d == 64'h4444, "R8 new line after ack", d, 64'h4444);
    do_lookup(16'h1005, 1'b0, '0, '0, 1'b0, 1'b0, h, d, dt);
    check(h && d == 64'h5555, "R7 new line at pointer", d, 64'h5555);
    do_lookup(16'h1002, 1'b0, '0, '0, 1'b0, 1'b0, h, d, dt);
    check(h && d == 64'h1002, "R7 younger line kept", d, 64'h1002);

    // R1: reset clears contents
    do_evict(16'h0400, 64'h0404, 1'b0);
    do_reset();
    check(lk_ready && ev_ready && !wb_valid, "R1 ready after reset",
          LW'({lk_ready, ev_ready, wb_valid}), 64'h6);
    do_lookup(16'h0400, 1'b0, '0, '0, 1'b0, 1'b0, h, d, dt);
    check(!h, "R1 entries cleared by reset", LW'(h), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule